// File: doc/BRIEF.md
# Dispatch-Group Store/Load Overlap Detector

This block keeps track of the memory stores issued into the current dispatch group. A scheduler uses it to spot a load that would read bytes one of those stores is still writing. Each recorded store is held as three values: a base-pointer identifier, a signed byte offset from that base, and an access size in bytes. A load is presented on a purely combinational query port. The block raises `ld_hit` when the load shares a base identifier with any recorded store and its byte range touches that store's range. The scheduler can then pad the group or start a new one. Raising `grp_clear` when a group closes empties the table for the next group.

The table has `DEPTH` slots, four by default. A three-state fill controller manages it:

- **FILL_EMPTY**: no slot holds a store.
- **FILL_PART**: some slots hold stores and at least one is free.
- **FILL_FULL**: every slot holds a store, and any further store is dropped.

The controller moves between states as follows:

- **record**: FILL_EMPTY to FILL_PART, or to FILL_FULL when `DEPTH` is 1.
- **record**: FILL_PART to FILL_PART, or to FILL_FULL when the last free slot is taken.
- **clear**: FILL_PART or FILL_FULL to FILL_EMPTY.
- **clear with record**: any state to FILL_PART, with the new store in slot 0.
- **hold**: the state is kept when nothing is recorded and nothing is cleared, which includes every store offered while in FILL_FULL.

Stores fill the slots in issue order, starting at slot 0. An access without memory-operand information is flagged by a low `*_has_mem`. Such a store is not recorded, and such a load is not checked.

Top module: `st_ld_overlap`

## Requirements
- R1: After reset the table is empty, and every load query returns `ld_hit` = 0.
- R2: A load whose base identifier and offset both equal those of a recorded store hits, whatever the two sizes are, including size 0.
- R3: With equal bases and the store offset below the load offset, the load hits exactly when store offset + store size > load offset.
- R4: With equal bases and the store offset above the load offset, the load hits exactly when load offset + load size > store offset.
- R5: A recorded store whose base identifier differs from the load's never causes a hit.
- R6: At most `DEPTH` (4) stores are recorded per group. Further stores are dropped until the next clear, and a load that overlaps only a dropped store does not hit.
- R7: A store offered with `st_has_mem` = 0 is not recorded. A load offered with `ld_has_mem` = 0 returns `ld_hit` = 0.
- R8: A cycle with `grp_clear` = 1 empties the table at the next edge. A store recorded in that same cycle is kept as the only entry of the new table. Queries during the clear cycle still see the old table.
- R9: Offsets are 16-bit two's complement, and sizes are 5-bit unsigned. The end-of-range sums do not wrap at either end of the offset range.
- R10: The query is combinational and sees only stores recorded on earlier clock edges. A store offered in the same cycle as a load is not visible to that load.
- R11: `ld_hit` is 0 whenever `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grp_clear | input | 1 | Dispatch group ends; empty the table at the next edge |
| st_valid | input | 1 | A store is issued this cycle |
| st_has_mem | input | 1 | The store carries memory-operand information |
| st_base | input | ID_W (8) | Store base-pointer identifier |
| st_ofs | input | OFS_W (16) | Store signed byte offset |
| st_size | input | SZ_W (5) | Store size in bytes |
| ld_valid | input | 1 | A load query is presented |
| ld_has_mem | input | 1 | The load carries memory-operand information |
| ld_base | input | ID_W (8) | Load base-pointer identifier |
| ld_ofs | input | OFS_W (16) | Load signed byte offset |
| ld_size | input | SZ_W (5) | Load size in bytes |
| ld_hit | output | 1 | The load overlaps a recorded store |

## Verification
The hardest situation to reach from the ports is the FILL_FULL state receiving a fifth store whose range would overlap a later load. Random traffic rarely reaches it, because clears keep arriving. The bench therefore drives a directed sequence of four recorded stores with no clear, then a fifth store, then a load aimed only at the fifth store. It adds directed loads at the extremes of the offset range, where a narrow adder would wrap. Random traffic then mixes clears, unannotated accesses and a small pool of base identifiers so that hits and misses both occur often.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_e;

    // Width that holds a sign-extended offset plus a zero-extended size
    // without wrapping.
    function automatic int sum_width(input int ofs_w, input int sz_w);
        int m;
        m = (ofs_w > sz_w + 1) ? ofs_w : sz_w + 1;
        return m + 1;
    endfunction

endpackage

// File: rtl/ovl_slot.sv
module ovl_slot #(
    parameter int ID_W  = 8,
    parameter int OFS_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [ID_W-1:0]         base_i,
    input  logic signed [OFS_W-1:0] ofs_i,
    input  logic [SZ_W-1:0]         size_i,
    output logic                    vld_o,
    output logic [ID_W-1:0]         base_o,
    output logic signed [OFS_W-1:0] ofs_o,
    output logic [SZ_W-1:0]         size_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o  <= 1'b0;
            base_o <= '0;
            ofs_o  <= '0;
            size_o <= '0;
        end else if (wr) begin
            vld_o  <= 1'b1;
            base_o <= base_i;
            ofs_o  <= ofs_i;
            size_o <= size_i;
        end else if (clr) begin
            vld_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/ovl_cmp.sv
module ovl_cmp #(
    parameter int ID_W  = 8,
    parameter int OFS_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic                    e_vld,
    input  logic [ID_W-1:0]         e_base,
    input  logic signed [OFS_W-1:0] e_ofs,
    input  logic [SZ_W-1:0]         e_size,
    input  logic [ID_W-1:0]         l_base,
    input  logic signed [OFS_W-1:0] l_ofs,
    input  logic [SZ_W-1:0]         l_size,
    output logic                    hit
);

    localparam int SUM_W = ovl_pkg::sum_width(OFS_W, SZ_W);

    logic signed [SUM_W-1:0] s_lo, s_end, l_lo, l_end, s_len, l_len;

    always_comb begin
        s_lo  = {{(SUM_W-OFS_W){e_ofs[OFS_W-1]}}, e_ofs};
        l_lo  = {{(SUM_W-OFS_W){l_ofs[OFS_W-1]}}, l_ofs};
        s_len = {{(SUM_W-SZ_W){1'b0}}, e_size};
        l_len = {{(SUM_W-SZ_W){1'b0}}, l_size};
        s_end = s_lo + s_len;
        l_end = l_lo + l_len;

        if (!e_vld || (e_base != l_base)) begin
            hit = 1'b0;
        end else if (s_lo == l_lo) begin
            hit = 1'b1;
        end else if (s_lo < l_lo) begin
            hit = (s_end > l_lo);
        end else begin
            hit = (l_end > s_lo);
        end
    end

endmodule

// File: rtl/ovl_fill_ctl.sv
module ovl_fill_ctl #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             rec,
    output logic [DEPTH-1:0] wr_en
);

    import ovl_pkg::*;

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    fill_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept;
    logic [CNT_W-1:0] wr_ptr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FILL_EMPTY: begin
                if (rec) begin
                    cnt_d   = ONE;
                    state_d = (ONE == LAST) ? FILL_FULL : FILL_PART;
                end
            end
            FILL_PART: begin
                if (clr) begin
                    cnt_d   = rec ? ONE : '0;
                    state_d = !rec ? FILL_EMPTY :
                              (ONE == LAST) ? FILL_FULL : FILL_PART;
                end else if (rec) begin
                    cnt_d   = cnt_q + ONE;
                    state_d = (cnt_q + ONE == LAST) ? FILL_FULL : FILL_PART;
                end
            end
            FILL_FULL: begin
                if (clr) begin
                    cnt_d   = rec ? ONE : '0;
                    state_d = !rec ? FILL_EMPTY :
                              (ONE == LAST) ? FILL_FULL : FILL_PART;
                end
            end
            default: begin
                state_d = FILL_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        accept = 1'b0;
        wr_ptr = '0;
        unique case (state_q)
            FILL_EMPTY: begin
                accept = rec;
                wr_ptr = '0;
            end
            FILL_PART: begin
                accept = rec;
                wr_ptr = clr ? '0 : cnt_q;
            end
            FILL_FULL: begin
                accept = rec && clr;
                wr_ptr = '0;
            end
            default: begin
                accept = 1'b0;
                wr_ptr = '0;
            end
        endcase
        for (int i = 0; i < DEPTH; i++) begin
            wr_en[i] = accept && (wr_ptr == CNT_W'(i));
        end
    end

endmodule

// File: rtl/st_ld_overlap.sv
module st_ld_overlap #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 8,
    parameter int OFS_W = 16,
    parameter int SZ_W  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    grp_clear,
    input  logic                    st_valid,
    input  logic                    st_has_mem,
    input  logic [ID_W-1:0]         st_base,
    input  logic signed [OFS_W-1:0] st_ofs,
    input  logic [SZ_W-1:0]         st_size,
    input  logic                    ld_valid,
    input  logic                    ld_has_mem,
    input  logic [ID_W-1:0]         ld_base,
    input  logic signed [OFS_W-1:0] ld_ofs,
    input  logic [SZ_W-1:0]         ld_size,
    output logic                    ld_hit
);

    logic                    st_rec;
    logic [DEPTH-1:0]        wr_en;
    logic [DEPTH-1:0]        slot_vld;
    logic [DEPTH-1:0]        slot_hit;
    logic [ID_W-1:0]         slot_base [DEPTH];
    logic signed [OFS_W-1:0] slot_ofs  [DEPTH];
    logic [SZ_W-1:0]         slot_size [DEPTH];

    assign st_rec = st_valid && st_has_mem;

    ovl_fill_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (grp_clear),
        .rec   (st_rec),
        .wr_en (wr_en)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        ovl_slot #(.ID_W(ID_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (grp_clear),
            .wr     (wr_en[g]),
            .base_i (st_base),
            .ofs_i  (st_ofs),
            .size_i (st_size),
            .vld_o  (slot_vld[g]),
            .base_o (slot_base[g]),
            .ofs_o  (slot_ofs[g]),
            .size_o (slot_size[g])
        );

        ovl_cmp #(.ID_W(ID_W), .OFS_W(OFS_W), .SZ_W(SZ_W)) u_cmp (
            .e_vld  (slot_vld[g]),
            .e_base (slot_base[g]),
            .e_ofs  (slot_ofs[g]),
            .e_size (slot_size[g]),
            .l_base (ld_base),
            .l_ofs  (ld_ofs),
            .l_size (ld_size),
            .hit    (slot_hit[g])
        );
    end

    assign ld_hit = ld_valid && ld_has_mem && (|slot_hit);

endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grp_clear,
    input logic             st_valid,
    input logic             st_has_mem,
    input logic             ld_valid,
    input logic             ld_has_mem,
    input logic             ld_hit,
    input logic [DEPTH-1:0] slot_vld
);

    logic rec;
    assign rec = st_valid && st_has_mem;

    // R1: an empty table never reports a hit
    p_empty_nohit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld == '0) |-> !ld_hit);

    // R7: a load without memory-operand information never hits
    p_load_nomem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_has_mem) |-> !ld_hit);

    // R7: a store without memory-operand information leaves the table alone
    p_store_nomem_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_clear && st_valid && !st_has_mem) |=> $stable(slot_vld));

    // R11: no query, no hit
    p_idle_nohit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> !ld_hit);

    // R8: a clear alone empties the table
    p_clear_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_clear && !rec) |=> (slot_vld == '0));

    // R8: a store in the clear cycle is the sole entry of the new table
    p_clear_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_clear && rec) |=> (slot_vld == DEPTH'(1)));

    // R6: a full table stays unchanged until cleared
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_clear && (&slot_vld)) |=> $stable(slot_vld));

    // R6: slots fill from slot 0 upward
    p_fill_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_vld & (slot_vld + DEPTH'(1))) == '0));

    // R10: an accepted store adds exactly one entry at the next edge
    p_record_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_clear && rec && !(&slot_vld)) |=>
        ($countones(slot_vld) == $past($countones(slot_vld)) + 1));

endmodule

bind st_ld_overlap ovl_checker #(.DEPTH(DEPTH)) u_ovl_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .grp_clear  (grp_clear),
    .st_valid   (st_valid),
    .st_has_mem (st_has_mem),
    .ld_valid   (ld_valid),
    .ld_has_mem (ld_has_mem),
    .ld_hit     (ld_hit),
    .slot_vld   (slot_vld)
);

// File: tb/test_st_ld_overlap.sv
module test_st_ld_overlap;

    localparam int DEPTH = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               grp_clear = 1'b0;
    logic               st_valid = 1'b0;
    logic               st_has_mem = 1'b0;
    logic [7:0]         st_base = '0;
    logic signed [15:0] st_ofs = '0;
    logic [4:0]         st_size = '0;
    logic               ld_valid = 1'b0;
    logic               ld_has_mem = 1'b0;
    logic [7:0]         ld_base = '0;
    logic signed [15:0] ld_ofs = '0;
    logic [4:0]         ld_size = '0;
    logic               ld_hit;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference table
    int m_base [DEPTH];
    int m_ofs  [DEPTH];
    int m_size [DEPTH];
    int m_cnt = 0;

    always #5 clk = ~clk;

    st_ld_overlap i_st_ld_overlap (
        .clk(clk), .rst_n(rst_n), .grp_clear(grp_clear),
        .st_valid(st_valid), .st_has_mem(st_has_mem),
        .st_base(st_base), .st_ofs(st_ofs), .st_size(st_size),
        .ld_valid(ld_valid), .ld_has_mem(ld_has_mem),
        .ld_base(ld_base), .ld_ofs(ld_ofs), .ld_size(ld_size),
        .ld_hit(ld_hit)
    );

    function automatic bit pair_hit(int sb, int so, int ss, int lb, int lo, int ls);
        if (sb != lb) return 1'b0;
        if (so == lo) return 1'b1;
        if (so < lo) return (so + ss) > lo;
        return (lo + ls) > so;
    endfunction

    function automatic bit model_hit(bit lv, bit lm, int lb, int lo, int ls);
        bit h = 1'b0;
        if (!lv || !lm) return 1'b0;
        for (int i = 0; i < m_cnt; i++)
            if (pair_hit(m_base[i], m_ofs[i], m_size[i], lb, lo, ls)) h = 1'b1;
        return h;
    endfunction

    task automatic step(input bit clr, input bit sv, input bit sm,
                        input int sb, input int so, input int ss,
                        input bit lv, input bit lm,
                        input int lb, input int lo, input int ls,
                        input string tag);
        bit exp;
        @(negedge clk);
        grp_clear  = clr;
        st_valid   = sv;
        st_has_mem = sm;
        st_base    = 8'(sb);
        st_ofs     = 16'(so);
        st_size    = 5'(ss);
        ld_valid   = lv;
        ld_has_mem = lm;
        ld_base    = 8'(lb);
        ld_ofs     = 16'(lo);
        ld_size    = 5'(ls);
        #1;
        exp = model_hit(lv, lm, lb, lo, ls);
        vectors++;
        if (ld_hit !== exp) begin
            fails++;
            $display("FAIL %s: ld_hit=%b expected %b (load base=%0d ofs=%0d size=%0d)",
                     tag, ld_hit, exp, lb, lo, ls);
        end
        @(posedge clk);
        if (clr) m_cnt = 0;
        if (sv && sm && m_cnt < DEPTH) begin
            m_base[m_cnt] = sb;
            m_ofs[m_cnt]  = so;
            m_size[m_cnt] = ss;
            m_cnt++;
        end
    endtask

    // load-only step
    task automatic ld(input int lb, input int lo, input int ls, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, 1, lb, lo, ls, tag);
    endtask

    // store-only step
    task automatic st(input int sb, input int so, input int ss, input string tag);
        step(0, 1, 1, sb, so, ss, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        ld(1, 100, 4, "R1 empty after reset");

        // R10: store and load in the same cycle, store not yet visible
        step(0, 1, 1, 1, 100, 8, 1, 1, 1, 100, 4, "R10 same-cycle store");
        // R2: exact match with zero sizes
        ld(1, 100, 0, "R2 exact match size 0");
        // R3: store below load
        ld(1, 107, 4, "R3 store end past load start");
        ld(1, 108, 4, "R3 store end at load start");
        // R4: store above load
        ld(1, 90, 10, "R4 load end at store start");
        ld(1, 90, 11, "R4 load end past store start");
        // R5: other base
        ld(2, 100, 8, "R5 different base");
        // R7 / R11: gating
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 100, 8, "R7 load without mem info");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 100, 8, "R11 load not valid");
        // R7: store without mem info is not recorded
        step(0, 1, 0, 3, 0, 4, 0, 0, 0, 0, 0, "R7 unannotated store");
        ld(3, 0, 4, "R7 unannotated store not recorded");

        // R6: fill to four, then a fifth is dropped
        st(4, 0, 4, "R6 fill");
        st(4, 16, 4, "R6 fill");
        st(4, 32, 4, "R6 fill");
        st(5, 0, 4, "R6 fifth store");
        ld(5, 0, 4, "R6 fifth store dropped");
        ld(4, 33, 1, "R6 fourth store kept");

        // R8: clear with store; query sees the old table in the clear cycle
        step(1, 1, 1, 6, 0, 4, 1, 1, 1, 100, 4, "R8 old table during clear");
        ld(1, 100, 4, "R8 table emptied");
        ld(6, 2, 1, "R8 clear-cycle store kept");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 clear");
        ld(6, 2, 1, "R8 clear alone empties");

        // R9: offset extremes
        st(7, 32760, 31, "R9 store near top");
        ld(7, 32766, 1, "R9 store end above top");
        st(8, -32768, 5, "R9 store at bottom");
        ld(8, 32767, 31, "R9 far apart");
        ld(8, -32764, 2, "R9 bottom overlap");
        ld(7, -32768, 31, "R9 load far below");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 clear");

        // constrained random traffic
        void'($urandom(32'd20240607));
        for (int n = 0; n < 3000; n++) begin
            bit clr = ($urandom_range(0, 7) == 0);
            bit sv  = ($urandom_range(0, 1) == 1);
            bit sm  = ($urandom_range(0, 7) != 0);
            bit lv  = ($urandom_range(0, 3) != 0);
            bit lm  = ($urandom_range(0, 7) != 0);
            int big = $urandom_range(0, 9);
            int so, lo;
            if (big == 0) begin
                so = 32767 - int'($urandom_range(0, 40));
                lo = 32767 - int'($urandom_range(0, 40));
            end else if (big == 1) begin
                so = -32768 + int'($urandom_range(0, 40));
                lo = -32768 + int'($urandom_range(0, 40));
            end else begin
                so = int'($urandom_range(0, 80)) - 40;
                lo = int'($urandom_range(0, 80)) - 40;
            end
            step(clr, sv, sm, int'($urandom_range(0, 2)), so, int'($urandom_range(0, 31)),
                 lv, lm, int'($urandom_range(0, 2)), lo, int'($urandom_range(0, 31)),
                 "R2|R3|R4|R5|R6|R8 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule